// File: doc/BRIEF.md
# Memory Checksum Walker

The checksum walker checks or repairs the 16-bit additive checksum of a word-addressed non-volatile memory. It reaches that memory through a simple request port that carries one transfer at a time. A single `start` pulse launches an operation, and `mode` selects which one. The walker takes the memory's word values at face value and does not know how the memory is reached underneath.

In check mode (`mode = 0`) it reads words 0 through the checksum index, inclusive. It adds them with 16-bit wrap-around and reports a pass when the total equals the signature 0xBABA. In fix mode (`mode = 1`) it sums only the words below the checksum index. It then writes the signature minus that partial sum into the checksum word, so that a later check passes.

Any transfer that returns an error ends the operation at once and is reported. `done` pulses for one cycle when an operation ends. `pass` and `err` then keep their values until the next accepted `start`.

Top module: `csum_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req`, `mem_we`, `pass` and `err` are all 0.
- R2: In check mode the block issues reads (`mem_we = 0`) to addresses 0, 1, ... CSUM_IDX, in ascending order, one request at a time, with no write.
- R3: In check mode, `pass` is 1 at the end exactly when the modulo-2^16 sum of words 0..CSUM_IDX equals 0xBABA.
- R4: In fix mode the block reads addresses 0..CSUM_IDX-1. It then issues one write (`mem_we = 1`) to CSUM_IDX with data equal to (0xBABA − sum) mod 2^16. `pass` is 1 when that write is acknowledged without error.
- R5: A read acknowledged with `mem_err = 1` ends the operation. No further request follows, `done` rises in the next cycle, `err` = 1 and `pass` = 0. In fix mode the checksum word is then not written.
- R6: In fix mode, a write acknowledged with `mem_err = 1` ends the operation with `err` = 1 and `pass` = 0.
- R7: `done` is high for exactly one cycle, in the cycle after the final acknowledge. `pass` and `err` hold their values until the next accepted `start`.
- R8: A `start` (with any `mode`) raised while `busy` is 1 is ignored. The running operation continues unchanged.
- R9: The running sum is cleared when an operation is accepted, so a result never depends on an earlier operation.
- R10: While `mem_req` is 1 and `mem_ack` is 0, the block holds `mem_req`, `mem_addr` and `mem_we` stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation when idle |
| mode | input | 1 | 0 = check, 1 = fix; sampled with start |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data (checksum value) |
| mem_ack | input | 1 | Request completes in this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_err | input | 1 | Transfer failed, valid with mem_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pass | output | 1 | Checksum matched / fix written |
| err | output | 1 | Operation aborted by a memory error |

## Verification
The bench drives memory contents whose sums wrap several times past 2^16. A design that drops the carry, or compares before the last word is added, would then report the wrong pass. Errors are injected on the first read, on a middle read and on the fix write. A walker that keeps going after an error, or writes a checksum anyway, shows up as extra requests or a changed checksum word. Back-to-back operations, a `start` raised in the middle of a run, and acknowledge latencies that vary per address catch three faults: a stale running sum, a restarted walk, and an address that moves before its acknowledge.

// File: rtl/csum_pkg.sv
`timescale 1ns/1ps
// Shared types for the checksum walker.
// Assumes: used by every module of the walker; holds no logic.
package csum_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } csum_state_e;

    localparam logic MODE_CHECK = 1'b0;
    localparam logic MODE_FIX   = 1'b1;
endpackage

// File: rtl/csum_accum.sv
`timescale 1ns/1ps
// Running modulo-2^DATA_W sum of the words read back.
// Assumes: clr and add_en never both high; sum_nxt is the sum including add_data.
module csum_accum #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] add_data,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] sum_nxt
);
    assign sum_nxt = acc + add_data;

    // Hold, clear or accumulate the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (add_en)
            acc <= sum_nxt;
    end
endmodule

// File: rtl/csum_addr_ctr.sv
`timescale 1ns/1ps
// Word address register for the memory walk.
// Assumes: load has priority over inc; wrap is never reached in normal use.
module csum_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    // Load a start address or step to the next word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc)
            addr <= addr + ADDR_W'(1);
    end
endmodule

// File: rtl/csum_fsm.sv
`timescale 1ns/1ps
// Sequencer: walks the read addresses, optionally writes the fix word,
// aborts on a memory error and keeps the pass / error result.
// Assumes: one request outstanding; mem_ack is high for exactly one cycle
// per request and completes it; CSUM_IDX fits in ADDR_W bits.
module csum_fsm
    import csum_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CSUM_IDX = 'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sum_hit,
    output logic              clr,
    output logic              add_en,
    output logic              load,
    output logic [ADDR_W-1:0] load_val,
    output logic              inc,
    output logic              mem_req,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              err
);
    localparam logic [ADDR_W-1:0] IDX      = ADDR_W'(CSUM_IDX);
    localparam logic [ADDR_W-1:0] LAST_FIX = IDX - ADDR_W'(1);
    localparam logic              HAS_PREFIX = (CSUM_IDX != 0);

    csum_state_e state, state_d;
    logic        mode_q;
    logic        last_rd;
    logic        rd_ok;

    assign last_rd = (addr == ((mode_q == MODE_FIX) ? LAST_FIX : IDX));
    assign rd_ok   = (state == ST_READ) && mem_ack && !mem_err;

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_FIN);
    assign mem_req = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we  = (state == ST_WRITE);

    // Next state and datapath controls.
    always_comb begin
        state_d  = state;
        clr      = 1'b0;
        add_en   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        inc      = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    clr  = 1'b1;
                    load = 1'b1;
                    if (mode == MODE_FIX && !HAS_PREFIX) begin
                        load_val = IDX;
                        state_d  = ST_WRITE;
                    end else begin
                        state_d  = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        state_d = ST_FIN;
                    end else begin
                        add_en = 1'b1;
                        if (last_rd) begin
                            if (mode_q == MODE_FIX) begin
                                load     = 1'b1;
                                load_val = IDX;
                                state_d  = ST_WRITE;
                            end else begin
                                state_d  = ST_FIN;
                            end
                        end else begin
                            inc = 1'b1;
                        end
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack)
                    state_d = ST_FIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // Latched mode and the result flags of the last operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CHECK;
            pass   <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                mode_q <= mode;
                pass   <= 1'b0;
                err    <= 1'b0;
            end else if (state == ST_READ && mem_ack) begin
                if (mem_err)
                    err <= 1'b1;
                else if (last_rd && mode_q == MODE_CHECK)
                    pass <= sum_hit;
            end else if (state == ST_WRITE && mem_ack) begin
                err  <= mem_err;
                pass <= !mem_err;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(addr) && $stable(mem_we));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R5
    rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) && mem_ack && mem_err |=> done && err && !pass && !mem_req);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok && !last_rd |=> mem_req && !mem_we && (addr == $past(addr) + ADDR_W'(1)));

    // R8
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && start |=> busy);

    // R6
    wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) && mem_ack && mem_err |=> done && err && !pass);
endmodule

// File: rtl/csum_walker.sv
`timescale 1ns/1ps
// Checksum walker top: joins the sequencer, the address register and the
// running-sum accumulator onto a single-outstanding memory request port.
// Assumes: the memory answers every request with exactly one mem_ack pulse.
module csum_walker #(
    parameter int              DATA_W    = 16,
    parameter int              ADDR_W    = 8,
    parameter int              CSUM_IDX  = 'h3F,
    parameter logic [DATA_W-1:0] SIGNATURE = DATA_W'('hBABA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              err
);
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(CSUM_IDX);

    logic              clr, add_en, load, inc;
    logic [ADDR_W-1:0] load_val;
    logic [DATA_W-1:0] acc, sum_nxt;
    logic              sum_hit;

    assign sum_hit   = (sum_nxt == SIGNATURE);
    assign mem_wdata = SIGNATURE - acc;

    csum_fsm #(
        .ADDR_W   (ADDR_W),
        .CSUM_IDX (CSUM_IDX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .addr     (mem_addr),
        .sum_hit  (sum_hit),
        .clr      (clr),
        .add_en   (add_en),
        .load     (load),
        .load_val (load_val),
        .inc      (inc),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .busy     (busy),
        .done     (done),
        .pass     (pass),
        .err      (err)
    );

    csum_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .inc      (inc),
        .addr     (mem_addr)
    );

    csum_accum #(
        .DATA_W (DATA_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .add_en   (add_en),
        .add_data (mem_rdata),
        .acc      (acc),
        .sum_nxt  (sum_nxt)
    );

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> (acc == '0));

    // R4
    fix_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_addr == IDX));
endmodule

// File: tb/csum_walker_tb.sv
`timescale 1ns/1ps
module csum_walker_tb;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int IDX = 'h3F;
    localparam logic [15:0] SIG = 16'hBABA;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start, mode;
    logic mem_req, mem_we, mem_ack, mem_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic busy, done, pass, err;

    csum_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .busy(busy), .done(done), .pass(pass), .err(err)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory model
    logic [15:0] mem [0:255];
    int lat_sel = 0;
    int err_addr = -1;
    bit err_we = 1'b0;
    int wait_cnt = 0;
    int ack_count = 0;

    // reference model state
    int ms = 0;
    int m_addr = 0;
    logic [15:0] m_acc = 0;
    bit m_pass = 0, m_err = 0, m_mode = 0, m_live = 0;

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_addr = 0; m_acc = 0; m_pass = 0; m_err = 0; m_mode = 0; m_live = 1;
        end else begin
            case (ms)
                0: if (start) begin
                    m_acc = 0; m_addr = 0; m_pass = 0; m_err = 0; m_mode = mode; ms = 1;
                end
                1: if (mem_ack) begin
                    if (mem_err) begin m_err = 1; ms = 3; end
                    else begin
                        m_acc = m_acc + mem_rdata;
                        if (m_addr == (m_mode ? IDX - 1 : IDX)) begin
                            if (m_mode) begin m_addr = IDX; ms = 2; end
                            else begin m_pass = (m_acc == SIG); ms = 3; end
                        end else m_addr++;
                    end
                end
                2: if (mem_ack) begin
                    if (mem_err) m_err = 1; else m_pass = 1;
                    ms = 3;
                end
                default: ms = 0;
            endcase
        end
    end

    // per-cycle comparison, then the memory responder
    always @(negedge clk) begin
        if (m_live) begin
            chk("R1 busy", busy, ms != 0);
            chk("R7 done", done, ms == 3);
            chk("R10 mem_req", mem_req, ms == 1 || ms == 2);
            chk("R2 mem_we", mem_we, ms == 2);
            if (ms == 1) chk("R2 mem_addr", mem_addr, m_addr);
            if (ms == 2) chk("R4 mem_addr", mem_addr, IDX);
            if (ms == 2) chk("R4 mem_wdata", mem_wdata, 16'(SIG - m_acc));
            chk("R3 pass", pass, m_pass);
            chk("R5 err", err, m_err);
        end
        if (!rst_n) begin
            mem_ack = 0; mem_err = 0; wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 0; mem_err = 0; wait_cnt = 0;
        end else if (mem_req) begin
            int lat;
            bit e;
            lat = (lat_sel == 4) ? int'(mem_addr) % 3 : lat_sel;
            if (wait_cnt >= lat) begin
                e = (int'(mem_addr) == err_addr) && (mem_we == err_we);
                mem_ack = 1; mem_err = e; ack_count++;
                if (!mem_we) mem_rdata = e ? 16'hDEAD : mem[mem_addr];
                else if (!e) mem[mem_addr] = mem_wdata;
                wait_cnt = 0;
            end else wait_cnt++;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = 0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) mem[i] = 16'((i + 3) * 40503 + seed * 7919 + 16'hC000);
    endtask

    task automatic run(input logic m);
        ack_count = 0;
        @(negedge clk); start = 1; mode = m;
        @(negedge clk); start = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R7 done one cycle", done, 0);
    endtask

    logic [15:0] saved;

    initial begin
        rst_n = 0; start = 0; mode = 0;
        mem_ack = 0; mem_err = 0; mem_rdata = 0;
        fill(1);
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset req", mem_req, 0);
        chk("R1 reset we", mem_we, 0);
        chk("R1 reset pass", pass, 0);
        chk("R1 reset err", err, 0);
        rst_n = 1;

        // check mode, matching image
        mem[IDX] = SIG - sum_to(IDX);
        lat_sel = 0;
        run(0);
        chk("R3 good image pass", pass, 1);
        chk("R2 read count", ack_count, IDX + 1);
        chk("R3 good image err", err, 0);

        // check mode, corrupted word
        mem[20] = mem[20] ^ 16'h0100;
        lat_sel = 2;
        run(0);
        chk("R3 corrupt image pass", pass, 0);
        chk("R3 corrupt image err", err, 0);

        // fix mode
        fill(2);
        lat_sel = 1;
        saved = SIG - sum_to(IDX);
        run(1);
        chk("R4 fix pass", pass, 1);
        chk("R4 fix word", mem[IDX], saved);
        chk("R4 fix count", ack_count, IDX + 1);

        // back-to-back check after fix
        lat_sel = 4;
        run(0);
        chk("R9 recheck pass", pass, 1);

        // read error in middle of check
        err_addr = 10; err_we = 0;
        run(0);
        chk("R5 mid err", err, 1);
        chk("R5 mid pass", pass, 0);
        chk("R5 mid count", ack_count, 11);

        // read error on first read of fix
        err_addr = 0;
        saved = mem[IDX];
        run(1);
        chk("R5 fix abort err", err, 1);
        chk("R5 fix abort count", ack_count, 1);
        chk("R5 fix no write", mem[IDX], saved);

        // write error on fix
        fill(3);
        err_addr = IDX; err_we = 1;
        run(1);
        chk("R6 write err", err, 1);
        chk("R6 write pass", pass, 0);

        // start while busy
        err_addr = -1; err_we = 0;
        fill(4);
        mem[IDX] = SIG - sum_to(IDX);
        saved = mem[IDX];
        lat_sel = 1;
        ack_count = 0;
        @(negedge clk); start = 1; mode = 0;
        @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        start = 1; mode = 1;
        @(negedge clk); start = 0; mode = 0;
        while (!done) @(negedge clk);
        chk("R8 busy start pass", pass, 1);
        chk("R8 busy start count", ack_count, IDX + 1);
        chk("R8 busy start no write", mem[IDX], saved);

        // result hold
        repeat (5) @(negedge clk);
        chk("R7 pass held", pass, 1);
        chk("R7 err held", err, 0);
        chk("R7 idle", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule